// File: doc/BRIEF.md
# Timed Motion Opcode Executor

This block turns a 4-bit motion opcode into a timed burst on four remote-control direction lines: forward, reverse, left and right. A controller places an opcode on `opcode` and raises `start`. On that rising edge the block latches the opcode's direction pattern and loads the opcode's duration, measured in slow ticks, into an internal one-shot. The pattern drives `drive` for exactly that many ticks. Then `drive` returns to zero and `done` pulses for one clock.

The slow tick comes from a clock divider with a ratio set by a parameter. Its tick is a single fast-clock cycle wide. The divider restarts on every accepted trigger, so the length of a burst is exact: duration times `DIV_RATIO` clock cycles. Delay opcodes run the same timer with all lines off. The zero-length no-op and the halt opcode finish at once. The controller that issues the opcodes treats `done` as "move on to the next one".

Top module: `motion_exec`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `drive` is 4'b0000 and `done` is 0.
- R2: Only a 0-to-1 transition of `start` (sampled on `clk`) starts a command. Holding `start` high after a command has finished starts nothing more: `drive` stays 0 and `done` stays 0.
- R3: Durations are given in ticks. Opcode 1 = 20 and opcode 10 = 20. Opcode 2 = 40 and opcode 9 = 40. Opcodes 3, 4, 11 and 12 = 12. Opcodes 5, 6, 13 and 14 = 24. Opcode 7 = 50. Opcode 8 = 100. Opcodes 0 and 15 = 0.
- R4: `drive` bit positions are [3] forward, [2] reverse, [1] left and [0] right. The patterns are: 1,2 → 1000; 3,5 → 1001; 4,6 → 1010; 9,10 → 0100; 11,13 → 0101; 12,14 → 0110.
- R5: Delay opcodes 7 and 8 keep `drive` at 0000 for their whole duration and then pulse `done`.
- R6: Opcodes 0 and 15 never assert `drive`. They pulse `done` in the cycle after the clock edge that accepts the trigger.
- R7: `done` is high for exactly one cycle. For a nonzero duration this is the cycle in which `drive` returns to 0000.
- R8: While a command is running, a new rising edge of `start` is ignored, and so is any change of `opcode`. The running pattern and its end time are unchanged.
- R9: Let edge k be the clock edge that accepts the trigger. For a duration of P ticks, the pattern shows in the P×`DIV_RATIO` cycles that follow edge k, and `done` shows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Trigger; its rising edge starts a command |
| opcode | input | 4 | Motion opcode, sampled on the accepting edge |
| drive | output | 4 | Direction lines {forward, reverse, left, right} |
| done | output | 1 | One-cycle pulse when a command ends |

## Verification
All sixteen opcodes run once in order, and then a seeded random sequence follows. For each command the bench checks the whole `drive` trace and the cycle in which `done` appears. Moving commands separate errors in the direction patterns from errors in duration. Delay opcodes separate timing from gating. Opcodes 0 and 15 exercise the immediate-done path. In about half of the random commands, `start` is dropped and raised again while the command runs, and `opcode` is changed at the same time. This shows whether re-triggering is blocked and whether the opcode is latched. Every command keeps `start` high for a few cycles after `done`, which catches a level-sensitive trigger.

// File: rtl/motion_pkg.sv
package motion_pkg;

   localparam int DIR_W = 4;
   localparam int DIR_FWD = 3;
   localparam int DIR_REV = 2;
   localparam int DIR_LFT = 1;
   localparam int DIR_RGT = 0;

   typedef logic [3:0] mop_t;
   typedef logic [DIR_W-1:0] dirs_t;

   // Tick counts: base unit is one slow tick
   localparam logic [7:0] T_STEP1  = 8'd20;
   localparam logic [7:0] T_STEP2  = 8'd40;
   localparam logic [7:0] T_TURN45 = 8'd12;
   localparam logic [7:0] T_TURN90 = 8'd24;
   localparam logic [7:0] T_WAIT_S = 8'd50;
   localparam logic [7:0] T_WAIT_L = 8'd100;

   function automatic logic [7:0] mop_ticks(input mop_t op);
      case (op)
         4'd1, 4'd10:                 mop_ticks = T_STEP1;
         4'd2, 4'd9:                  mop_ticks = T_STEP2;
         4'd3, 4'd4, 4'd11, 4'd12:    mop_ticks = T_TURN45;
         4'd5, 4'd6, 4'd13, 4'd14:    mop_ticks = T_TURN90;
         4'd7:                        mop_ticks = T_WAIT_S;
         4'd8:                        mop_ticks = T_WAIT_L;
         default:                     mop_ticks = 8'd0;
      endcase
   endfunction

   function automatic dirs_t mop_dirs(input mop_t op);
      dirs_t d;
      d = '0;
      case (op)
         4'd1, 4'd2:   d[DIR_FWD] = 1'b1;
         4'd3, 4'd5:   begin d[DIR_FWD] = 1'b1; d[DIR_RGT] = 1'b1; end
         4'd4, 4'd6:   begin d[DIR_FWD] = 1'b1; d[DIR_LFT] = 1'b1; end
         4'd9, 4'd10:  d[DIR_REV] = 1'b1;
         4'd11, 4'd13: begin d[DIR_REV] = 1'b1; d[DIR_RGT] = 1'b1; end
         4'd12, 4'd14: begin d[DIR_REV] = 1'b1; d[DIR_LFT] = 1'b1; end
         default:      d = '0;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/motion_decode.sv
module motion_decode
   import motion_pkg::*;
#(
   parameter int PERIOD_W = 8
) (
   input  logic [3:0]          op,
   output logic [PERIOD_W-1:0] period,
   output logic [DIR_W-1:0]    dirs
);

   always_comb begin
      period = PERIOD_W'(mop_ticks(op));
      dirs   = mop_dirs(op);
   end

endmodule

// File: rtl/motion_tick_div.sv
module motion_tick_div #(
   parameter int DIV_RATIO = 500000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   output logic tick
);

   localparam int CNT_W = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_RATIO - 1);
   localparam bit IS_POW2 = ((DIV_RATIO & (DIV_RATIO - 1)) == 0);

   logic [CNT_W-1:0] cnt;

   generate
      if (DIV_RATIO < 2) begin : g_bad_ratio
         $error("motion_tick_div: DIV_RATIO must be at least 2");
      end

      if (IS_POW2) begin : g_wrap
         always_ff @(posedge clk) begin
            if (!rst_n || clear) cnt <= '0;
            else                 cnt <= cnt + 1'b1;
         end
         assign tick = &cnt;
      end else begin : g_cmp
         always_ff @(posedge clk) begin
            if (!rst_n || clear || cnt == LAST) cnt <= '0;
            else                                cnt <= cnt + 1'b1;
         end
         assign tick = (cnt == LAST);
      end
   endgenerate

   // R9
   tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

endmodule

// File: rtl/motion_oneshot.sv
module motion_oneshot #(
   parameter int PERIOD_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                trig,
   input  logic [PERIOD_W-1:0] period,
   input  logic                tick,
   output logic                fire,
   output logic                active,
   output logic                done
);

   logic                trig_q;
   logic [PERIOD_W-1:0] remain;

   assign fire = trig && !trig_q && !active;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trig_q <= 1'b0;
         active <= 1'b0;
         done   <= 1'b0;
         remain <= '0;
      end else begin
         trig_q <= trig;
         done   <= 1'b0;
         if (fire) begin
            if (period == '0) begin
               done <= 1'b1;
            end else begin
               active <= 1'b1;
               remain <= period;
            end
         end else if (active && tick) begin
            remain <= remain - 1'b1;
            if (remain == PERIOD_W'(1)) begin
               active <= 1'b0;
               done   <= 1'b1;
            end
         end
      end
   end

   // R7
   done_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active) |-> done);

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R3
   remain_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (remain != '0));

   // R8
   no_retrig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && trig && !trig_q && !tick) |=> (active && $stable(remain)));

endmodule

// File: rtl/motion_exec.sv
module motion_exec
   import motion_pkg::*;
#(
   parameter int DIV_RATIO = 500000,
   parameter int PERIOD_W  = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [3:0] opcode,
   output logic [3:0] drive,
   output logic       done
);

   logic [PERIOD_W-1:0] dec_period;
   logic [DIR_W-1:0]    dec_dirs;
   logic [DIR_W-1:0]    pat_r;
   logic                tick;
   logic                fire;
   logic                active;

   generate
      if (PERIOD_W < 8) begin : g_bad_width
         $error("motion_exec: PERIOD_W must be at least 8");
      end
   endgenerate

   motion_decode #(.PERIOD_W(PERIOD_W)) u_decode (
      .op     (opcode),
      .period (dec_period),
      .dirs   (dec_dirs)
   );

   motion_tick_div #(.DIV_RATIO(DIV_RATIO)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (fire),
      .tick  (tick)
   );

   motion_oneshot #(.PERIOD_W(PERIOD_W)) u_shot (
      .clk    (clk),
      .rst_n  (rst_n),
      .trig   (start),
      .period (dec_period),
      .tick   (tick),
      .fire   (fire),
      .active (active),
      .done   (done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)    pat_r <= '0;
      else if (fire) pat_r <= dec_dirs;
   end

   assign drive = active ? pat_r : '0;

   // R8
   drive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && $past(active)) |-> $stable(drive));

   // R5
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> (drive == '0));

   // R6
   zero_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && dec_period == '0) |=> (done && drive == '0));

endmodule

// File: tb/motion_exec_tb.sv
module motion_exec_tb;

   localparam int CLK_PERIOD = 10;
   localparam int DIV        = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [3:0] opcode = 4'd0;
   logic [3:0] drive;
   logic       done;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   motion_exec #(.DIV_RATIO(DIV), .PERIOD_W(8)) u_dut (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .opcode (opcode),
      .drive  (drive),
      .done   (done)
   );

   function automatic int exp_ticks(input logic [3:0] op);
      case (op)
         4'd1, 4'd10:              return 20;
         4'd2, 4'd9:               return 40;
         4'd3, 4'd4, 4'd11, 4'd12: return 12;
         4'd5, 4'd6, 4'd13, 4'd14: return 24;
         4'd7:                     return 50;
         4'd8:                     return 100;
         default:                  return 0;
      endcase
   endfunction

   // bits: [3] fwd [2] rev [1] left [0] right
   function automatic logic [3:0] exp_dir(input logic [3:0] op);
      case (op)
         4'd1, 4'd2:   return 4'b1000;
         4'd3, 4'd5:   return 4'b1001;
         4'd4, 4'd6:   return 4'b1010;
         4'd9, 4'd10:  return 4'b0100;
         4'd11, 4'd13: return 4'b0101;
         4'd12, 4'd14: return 4'b0110;
         default:      return 4'b0000;
      endcase
   endfunction

   task automatic run_op(input logic [3:0] op, input bit poke, input logic [3:0] alt);
      int len;
      int bad_dir;
      int bad_done;
      logic [3:0] pat;
      logic [3:0] want_d;
      string tag;
      len = exp_ticks(op) * DIV;
      pat = exp_dir(op);
      if (len == 0)        tag = "R6";
      else if (pat == 0)   tag = "R5";
      else if (poke)       tag = "R8";
      else                 tag = "R3/R4/R9";
      bad_dir = 0;
      bad_done = 0;
      @(negedge clk);
      opcode = op;
      start  = 1'b1;
      for (int i = 0; i <= len + 3; i++) begin
         @(negedge clk);
         want_d = (i < len) ? pat : 4'b0000;
         if (drive !== want_d) begin
            if (bad_dir == 0)
               $display("FAIL %s op=%0d cycle %0d drive actual=%b expected=%b",
                        tag, op, i, drive, want_d);
            bad_dir++;
         end
         if (done !== (i == len)) begin
            if (bad_done == 0)
               $display("FAIL R7/R2 op=%0d cycle %0d done actual=%b expected=%b",
                        op, i, done, (i == len));
            bad_done++;
         end
         if (poke && len >= 8) begin
            if (i == 1) begin start = 1'b0; opcode = alt; end
            if (i == 2) start = 1'b1;
         end
      end
      start = 1'b0;
      checks += 2;
      if (bad_dir != 0)  errors++;
      if (bad_done != 0) errors++;
   endtask

   initial begin
      void'($urandom(32'h5EED));
      repeat (3) @(negedge clk);
      // R1: reset state
      checks++;
      if (drive !== 4'b0000) begin
         errors++;
         $display("FAIL R1 drive in reset actual=%b expected=0000", drive);
      end
      checks++;
      if (done !== 1'b0) begin
         errors++;
         $display("FAIL R1 done in reset actual=%b expected=0", done);
      end
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (drive !== 4'b0000 || done !== 1'b0) begin
         errors++;
         $display("FAIL R1 after release actual=%b/%b expected=0000/0", drive, done);
      end
      // directed: every opcode once, R2 hold-after-done inside run_op
      for (int k = 0; k < 16; k++) run_op(4'(k), 1'b0, 4'd0);
      // directed: retrigger during a long move (R8)
      run_op(4'd2, 1'b1, 4'd9);
      run_op(4'd8, 1'b1, 4'd1);
      // random mix
      for (int k = 0; k < 40; k++) begin
         logic [3:0] op_r;
         logic [3:0] alt_r;
         bit poke_r;
         op_r   = 4'($urandom % 16);
         alt_r  = 4'($urandom % 16);
         poke_r = 1'($urandom % 2);
         run_op(op_r, poke_r, alt_r);
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule